// File: doc/BRIEF.md
# Narrow-to-Wide Line Packer with Partitioned Line Store

This block gathers 32-bit words from user logic into 128-bit lines and files each line into one of eight virtual FIFO partitions. Every accepted word carries a port tag, a 3-bit partition select, a 4-bit byte-valid mask, an end-of-packet marker and a few control sideband bits. Words collect in a hold register. The line is written when the fourth word arrives, or at once when end-of-packet arrives. The storage is four 32-bit lane banks that share one address, so each line occupies one row across all four lanes. A parallel control store keeps the per-line record: port, sideband, valid-word count and end-of-packet flag. Byte-valid masks never enter the control store. Instead they zero the disabled bytes before storage.

The shared rows are split into eight equal partitions. Each partition has its own write and read pointers, a full flag, an empty flag and a sticky overflow flag. A reader pops the oldest line of a chosen partition through a simple request port. The result appears one cycle later.

The word input is valid/ready. A word transfers on a rising edge where `in_valid` and `in_ready` are both high. While `in_valid` is high the source must hold every payload field stable until the transfer. `in_ready` drops for exactly one cycle when a word asks for a partition other than the one the partly built line belongs to. That cycle flushes the held words. The word is then accepted on the following edge. A full partition does not cause back-pressure. The line is discarded instead.

Top module: `line_packer`

## Requirements
- R1: After reset, all eight partitions report empty, none reports full, all overflow flags are clear, `rd_vld` is low and `in_ready` is high while `in_valid` is low.
- R2: Four accepted words with the same partition select form one line in that partition. The first word occupies bits 31:0 and the k-th word occupies bits 32k+31:32k. The stored word count is 4.
- R3: A word accepted with `in_eop` high closes the line at once. The stored count equals the words in the line (1 to 4), the end-of-packet flag reads 1, and unused word slots read as zero.
- R4: A byte whose `in_be` bit is 0 (bit b covers data bits 8b+7:8b) reads back as zero. The byte-valid bits appear in no field of the read record.
- R5: A valid word whose partition select differs from that of a non-empty partial line sees `in_ready` low for one cycle. In that cycle the held words are written to the old partition with end-of-packet flag 0. The word is then accepted as the first word of a new line.
- R6: The port and control sideband stored with a line are those of its first word.
- R7: Each partition returns its lines oldest first, independently of writes and reads on other partitions.
- R8: A partition reports full when it holds `PART_LINES` lines and empty when it holds none.
- R9: A line directed to a full partition is discarded and sets that partition's overflow flag. The flag stays set until reset and the stored lines are unaffected.
- R10: `rd_req` with `rd_part` pops the oldest line of that partition and `rd_vld` rises on the following cycle with the record. A request on an empty partition produces no `rd_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Word can be taken this cycle |
| in_data | input | 32 | Word payload |
| in_be | input | 4 | Byte-valid mask, bit b for byte b |
| in_port | input | PORT_W | Port tag |
| in_fifo | input | 3 | Destination partition |
| in_eop | input | 1 | Last word of packet |
| in_ctl | input | CTL_W | Control sideband |
| rd_req | input | 1 | Pop request |
| rd_part | input | 3 | Partition to pop |
| rd_vld | output | 1 | Read record valid |
| rd_line | output | 128 | Popped line |
| rd_words | output | 3 | Valid words in popped line |
| rd_port | output | PORT_W | Port tag of popped line |
| rd_ctl | output | CTL_W | Sideband of popped line |
| rd_eop | output | 1 | Popped line ended a packet |
| part_full | output | 8 | Per-partition full flag |
| part_empty | output | 8 | Per-partition empty flag |
| part_ovf | output | 8 | Per-partition sticky overflow |

## Verification
The hardest case to reach is the overflow path: a partition must be at full occupancy at the moment a line closes for it. Lines closed by end-of-packet let the stimulus fill one partition in a few words. A further line is then closed into it. The bench drains that partition to show the discarded line never appears and the overflow flag survives the drain. The partition-switch stall is provoked by changing the select after two held words. The bench confirms the one-cycle `in_ready` drop before the word is accepted.

// File: rtl/lp_pkg.sv
package lp_pkg;
  localparam int WORD_W   = 32;
  localparam int LANES    = 4;
  localparam int LINE_W   = WORD_W * LANES;
  localparam int NPART    = 8;
  localparam int PSEL_W   = 3;
  localparam int WCNT_W   = 3;

  function automatic logic [WORD_W-1:0] keep_bytes(input logic [WORD_W-1:0] d,
                                                   input logic [LANES-1:0] be);
    logic [WORD_W-1:0] r;
    for (int b = 0; b < LANES; b++) r[8*b +: 8] = be[b] ? d[8*b +: 8] : 8'h00;
    return r;
  endfunction
endpackage

// File: rtl/lp_mem.sv
module lp_mem #(
  parameter int W     = 32,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/lp_hold.sv
module lp_hold
  import lp_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int CTL_W  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [WORD_W-1:0]   in_data,
  input  logic [LANES-1:0]    in_be,
  input  logic [PORT_W-1:0]   in_port,
  input  logic [PSEL_W-1:0]   in_fifo,
  input  logic                in_eop,
  input  logic [CTL_W-1:0]    in_ctl,
  output logic                wr_fire,
  output logic [PSEL_W-1:0]   wr_part,
  output logic [LINE_W-1:0]   wr_line,
  output logic [WCNT_W-1:0]   wr_words,
  output logic [PORT_W-1:0]   wr_port,
  output logic [CTL_W-1:0]    wr_ctl,
  output logic                wr_eop
);
  logic [1:0]                   cnt;
  logic [LANES-1:0][WORD_W-1:0] held;
  logic [PSEL_W-1:0]            h_part;
  logic [PORT_W-1:0]            h_port;
  logic [CTL_W-1:0]             h_ctl;

  logic switch_flush, take, close;
  logic [WORD_W-1:0] masked;

  assign masked       = keep_bytes(in_data, in_be);
  assign switch_flush = in_valid && (cnt != 2'd0) && (in_fifo != h_part);
  assign in_ready     = !switch_flush;
  assign take         = in_valid && in_ready;
  assign close        = take && ((cnt == 2'd3) || in_eop);
  assign wr_fire      = switch_flush || close;

  assign wr_part  = (cnt == 2'd0) ? in_fifo : h_part;
  assign wr_port  = (cnt == 2'd0) ? in_port : h_port;
  assign wr_ctl   = (cnt == 2'd0) ? in_ctl  : h_ctl;
  assign wr_eop   = close && in_eop;
  assign wr_words = switch_flush ? {1'b0, cnt} : ({1'b0, cnt} + 3'd1);

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      if (i < int'(cnt))                 wr_line[WORD_W*i +: WORD_W] = held[i];
      else if (take && i == int'(cnt))   wr_line[WORD_W*i +: WORD_W] = masked;
      else                               wr_line[WORD_W*i +: WORD_W] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= 2'd0;
      held   <= '0;
      h_part <= '0;
      h_port <= '0;
      h_ctl  <= '0;
    end else if (switch_flush) begin
      cnt <= 2'd0;
    end else if (take) begin
      if (close) begin
        cnt <= 2'd0;
      end else begin
        held[cnt] <= masked;
        cnt       <= cnt + 2'd1;
        if (cnt == 2'd0) begin
          h_part <= in_fifo;
          h_port <= in_port;
          h_ctl  <= in_ctl;
        end
      end
    end
  end

  // R3
  line_count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> (wr_words != 3'd0 && wr_words <= 3'd4));

  // R5
  switch_empties_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> (cnt == 2'd0));
endmodule

// File: rtl/lp_ptrs.sv
module lp_ptrs
  import lp_pkg::*;
#(
  parameter int PART_LINES = 4,
  localparam int IW = $clog2(PART_LINES),
  localparam int PW = IW + 1,
  localparam int AW = PSEL_W + IW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_req,
  input  logic [PSEL_W-1:0] push_part,
  input  logic              pop_req,
  input  logic [PSEL_W-1:0] pop_part,
  output logic              push_ok,
  output logic              pop_ok,
  output logic [AW-1:0]     waddr,
  output logic [AW-1:0]     raddr,
  output logic [NPART-1:0]  full,
  output logic [NPART-1:0]  empty,
  output logic [NPART-1:0]  ovf
);
  logic [NPART-1:0][PW-1:0] wp_v, rp_v;

  assign push_ok = push_req && !full[push_part];
  assign pop_ok  = pop_req && !empty[pop_part];
  assign waddr   = {push_part, wp_v[push_part][IW-1:0]};
  assign raddr   = {pop_part,  rp_v[pop_part][IW-1:0]};

  for (genvar p = 0; p < NPART; p++) begin : g_part
    logic [PW-1:0] wp, rp;
    logic          sticky;

    assign wp_v[p]  = wp;
    assign rp_v[p]  = rp;
    assign full[p]  = ((wp - rp) == PW'(PART_LINES));
    assign empty[p] = (wp == rp);
    assign ovf[p]   = sticky;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wp     <= '0;
        rp     <= '0;
        sticky <= 1'b0;
      end else begin
        if (push_ok && push_part == PSEL_W'(p)) wp <= wp + 1'b1;
        if (pop_ok  && pop_part  == PSEL_W'(p)) rp <= rp + 1'b1;
        if (push_req && push_part == PSEL_W'(p) && full[p]) sticky <= 1'b1;
      end
    end
  end

  // R8
  full_empty_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full & empty) == '0);

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ovf & $past(ovf)) == $past(ovf)));

  // R9
  push_to_full_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && full[push_part]) |=> ovf[$past(push_part)]);
endmodule

// File: rtl/line_packer.sv
module line_packer
  import lp_pkg::*;
#(
  parameter int PORT_W     = 8,
  parameter int CTL_W      = 4,
  parameter int PART_LINES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_data,
  input  logic [3:0]        in_be,
  input  logic [PORT_W-1:0] in_port,
  input  logic [2:0]        in_fifo,
  input  logic              in_eop,
  input  logic [CTL_W-1:0]  in_ctl,
  input  logic              rd_req,
  input  logic [2:0]        rd_part,
  output logic              rd_vld,
  output logic [127:0]      rd_line,
  output logic [2:0]        rd_words,
  output logic [PORT_W-1:0] rd_port,
  output logic [CTL_W-1:0]  rd_ctl,
  output logic              rd_eop,
  output logic [7:0]        part_full,
  output logic [7:0]        part_empty,
  output logic [7:0]        part_ovf
);
  localparam int LINES = NPART * PART_LINES;
  localparam int AW    = $clog2(LINES);
  localparam int REC_W = 1 + WCNT_W + PORT_W + CTL_W;

  logic              wr_fire, wr_eop, push_ok, pop_ok;
  logic [PSEL_W-1:0] wr_part;
  logic [LINE_W-1:0] wr_line;
  logic [WCNT_W-1:0] wr_words;
  logic [PORT_W-1:0] wr_port;
  logic [CTL_W-1:0]  wr_ctl;
  logic [AW-1:0]     waddr, raddr;
  logic [REC_W-1:0]  rec_out;

  lp_hold #(.PORT_W(PORT_W), .CTL_W(CTL_W)) u_hold (
    .clk, .rst_n, .in_valid, .in_ready, .in_data, .in_be, .in_port,
    .in_fifo, .in_eop, .in_ctl, .wr_fire, .wr_part, .wr_line,
    .wr_words, .wr_port, .wr_ctl, .wr_eop
  );

  lp_ptrs #(.PART_LINES(PART_LINES)) u_ptrs (
    .clk, .rst_n, .push_req(wr_fire), .push_part(wr_part),
    .pop_req(rd_req), .pop_part(rd_part), .push_ok, .pop_ok,
    .waddr, .raddr, .full(part_full), .empty(part_empty), .ovf(part_ovf)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    lp_mem #(.W(WORD_W), .DEPTH(LINES)) u_bank (
      .clk, .we(push_ok), .waddr, .wdata(wr_line[WORD_W*k +: WORD_W]),
      .re(pop_ok), .raddr, .rdata(rd_line[WORD_W*k +: WORD_W])
    );
  end

  lp_mem #(.W(REC_W), .DEPTH(LINES)) u_rec (
    .clk, .we(push_ok), .waddr,
    .wdata({wr_eop, wr_words, wr_port, wr_ctl}),
    .re(pop_ok), .raddr, .rdata(rec_out)
  );

  assign {rd_eop, rd_words, rd_port, rd_ctl} = rec_out;

  always_ff @(posedge clk) begin
    if (!rst_n) rd_vld <= 1'b0;
    else        rd_vld <= pop_ok;
  end

  // R10
  read_follows_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld |-> $past(rd_req));

  // R3
  read_count_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld |-> (rd_words != 3'd0 && rd_words <= 3'd4));
endmodule

// File: tb/line_packer_bench.sv
module line_packer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PL = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_eop = 1'b0, rd_req = 1'b0;
  logic in_ready, rd_vld, rd_eop;
  logic [31:0] in_data = '0;
  logic [3:0] in_be = '0, in_ctl = '0, rd_ctl;
  logic [7:0] in_port = '0, rd_port, part_full, part_empty, part_ovf;
  logic [2:0] in_fifo = '0, rd_part = '0, rd_words;
  logic [127:0] rd_line;

  typedef struct packed {
    logic [127:0] line; logic [2:0] words; logic [7:0] port; logic [3:0] ctl; logic eop;
  } rec_t;

  rec_t mq [8][PL];
  int mhead[8], mcount[8];
  bit movf[8];
  rec_t rd_exp[$];
  string tag_q[$];
  logic [127:0] mline = '0;
  int mwords = 0;
  logic [2:0] mfifo = '0;
  logic [7:0] mport = '0;
  logic [3:0] mctl = '0;
  int total = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  line_packer #(.PORT_W(8), .CTL_W(4), .PART_LINES(PL)) u_line_packer (
    .clk, .rst_n, .in_valid, .in_ready, .in_data, .in_be, .in_port, .in_fifo,
    .in_eop, .in_ctl, .rd_req, .rd_part, .rd_vld, .rd_line, .rd_words,
    .rd_port, .rd_ctl, .rd_eop, .part_full, .part_empty, .part_ovf
  );

  task automatic check(bit ok, string tag, string what, logic [127:0] act, logic [127:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] keep(logic [31:0] d, logic [3:0] be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = be[b] ? d[8*b +: 8] : 8'h00;
    return r;
  endfunction

  task automatic commit(bit eop);
    rec_t e;
    e.line = mline; e.words = 3'(mwords); e.port = mport; e.ctl = mctl; e.eop = eop;
    if (mcount[mfifo] == PL) movf[mfifo] = 1;
    else begin
      mq[mfifo][(mhead[mfifo] + mcount[mfifo]) % PL] = e;
      mcount[mfifo]++;
    end
    mline = '0; mwords = 0;
  endtask

  task automatic send(logic [31:0] d, logic [3:0] be, logic [7:0] port,
                      logic [2:0] f, bit eop, logic [3:0] ctl);
    in_valid = 1; in_data = d; in_be = be; in_port = port;
    in_fifo = f; in_eop = eop; in_ctl = ctl;
    #1;
    if (mwords != 0 && f != mfifo) begin
      // R5: stall for one cycle while the old line is flushed
      check(in_ready == 1'b0, "R5", "ready during switch", 128'(in_ready), 128'(0));
      commit(0);
      @(posedge clk); @(negedge clk); #1;
    end
    check(in_ready == 1'b1, "R5", "ready for word", 128'(in_ready), 128'(1));
    if (mwords == 0) begin mfifo = f; mport = port; mctl = ctl; end
    mline[32*mwords +: 32] = keep(d, be);
    mwords++;
    if (mwords == 4 || eop) commit(eop);
    @(posedge clk); @(negedge clk);
    in_valid = 0; in_eop = 0;
  endtask

  task automatic rd(int p, string tag);
    rd_req = 1; rd_part = 3'(p);
    if (mcount[p] > 0) begin
      rd_exp.push_back(mq[p][mhead[p]]);
      tag_q.push_back(tag);
      mhead[p] = (mhead[p] + 1) % PL;
      mcount[p]--;
      @(posedge clk); @(negedge clk);
      rd_req = 0;
    end else begin
      @(posedge clk); @(negedge clk);
      rd_req = 0;
      // R10: pop of an empty partition yields nothing
      check(rd_vld == 1'b0, tag, "read of empty partition", 128'(rd_vld), 128'(0));
    end
  endtask

  task automatic check_flags(string tag);
    logic [7:0] ef, ee, eo;
    for (int p = 0; p < 8; p++) begin
      ef[p] = (mcount[p] == PL); ee[p] = (mcount[p] == 0); eo[p] = movf[p];
    end
    // R8 full and empty flags, R9 overflow flags
    check(part_full == ef, tag, "full flags (R8)", 128'(part_full), 128'(ef));
    check(part_empty == ee, tag, "empty flags (R8)", 128'(part_empty), 128'(ee));
    check(part_ovf == eo, tag, "overflow flags (R9)", 128'(part_ovf), 128'(eo));
  endtask

  // monitor: compare every popped record with the scoreboard
  always @(negedge clk) begin
    if (rst_n && rd_vld) begin
      if (rd_exp.size() == 0) begin
        check(0, "R10", "unexpected rd_vld", 128'(1), 128'(0));
      end else begin
        rec_t e;
        string t;
        e = rd_exp.pop_front();
        t = tag_q.pop_front();
        check(rd_line == e.line, t, "line data", rd_line, e.line);
        check({rd_words, rd_port, rd_ctl, rd_eop} == {e.words, e.port, e.ctl, e.eop},
              t, "record words/port/ctl/eop",
              128'({rd_words, rd_port, rd_ctl, rd_eop}), 128'({e.words, e.port, e.ctl, e.eop}));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < 8; p++) begin mhead[p] = 0; mcount[p] = 0; movf[p] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    check(in_ready == 1'b1, "R1", "ready after reset", 128'(in_ready), 128'(1));
    check(rd_vld == 1'b0, "R1", "rd_vld after reset", 128'(rd_vld), 128'(0));
    check_flags("R1");

    // R2: four full words into partition 0
    send(32'h0000_0A01, 4'hF, 8'h11, 3'd0, 0, 4'h3);
    send(32'h0000_0A02, 4'hF, 8'h12, 3'd0, 0, 4'h4);
    send(32'h0000_0A03, 4'hF, 8'h13, 3'd0, 0, 4'h5);
    send(32'h0000_0A04, 4'hF, 8'h14, 3'd0, 0, 4'h6);
    check_flags("R2");
    rd(0, "R2");

    // R3: end-of-packet after two words
    send(32'hB0B0_0001, 4'hF, 8'h21, 3'd3, 0, 4'h1);
    send(32'hB0B0_0002, 4'hF, 8'h22, 3'd3, 1, 4'h2);
    rd(3, "R3");

    // R4: byte masking
    send(32'hDEAD_BEEF, 4'b0101, 8'h31, 3'd4, 1, 4'h7);
    rd(4, "R4");

    // R5: partition switch mid-line
    send(32'h5555_0001, 4'hF, 8'h41, 3'd1, 0, 4'h8);
    send(32'h5555_0002, 4'hF, 8'h42, 3'd1, 0, 4'h8);
    send(32'h6666_0001, 4'hF, 8'h51, 3'd5, 0, 4'h9);
    send(32'h6666_0002, 4'hC, 8'h52, 3'd5, 0, 4'h9);
    send(32'h6666_0003, 4'h3, 8'h53, 3'd5, 0, 4'h9);
    send(32'h6666_0004, 4'hF, 8'h54, 3'd5, 0, 4'h9);
    rd(1, "R5");
    rd(5, "R5");

    // R6: port and sideband from first word
    send(32'h7777_0001, 4'hF, 8'hA1, 3'd6, 0, 4'hA);
    send(32'h7777_0002, 4'hF, 8'hA2, 3'd6, 0, 4'hB);
    send(32'h7777_0003, 4'hF, 8'hA3, 3'd6, 1, 4'hC);
    rd(6, "R6");

    // R7: interleaved partitions keep their own order
    send(32'h7000_0001, 4'hF, 8'h71, 3'd7, 1, 4'h1);
    send(32'h0000_0001, 4'hF, 8'h01, 3'd0, 1, 4'h2);
    send(32'h7000_0002, 4'hF, 8'h72, 3'd7, 1, 4'h3);
    send(32'h0000_0002, 4'hF, 8'h02, 3'd0, 1, 4'h4);
    rd(0, "R7");
    rd(7, "R7");
    rd(0, "R7");
    rd(7, "R7");

    // R8 / R9: fill partition 2, then overflow it
    for (int i = 0; i < PL + 1; i++)
      send(32'h2200_0000 + 32'(i), 4'hF, 8'(8'h60 + i), 3'd2, 1, 4'(i));
    check_flags("R9");
    for (int i = 0; i < PL; i++) rd(2, "R9");
    check_flags("R9");

    // R10: read of an empty partition
    rd(2, "R10");
    rd(6, "R10");
    check_flags("R10");

    repeat (2) @(negedge clk);
    check(rd_exp.size() == 0, "R10", "pending reads drained", 128'(rd_exp.size()), 128'(0));
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end
endmodule